// File: doc/BRIEF.md
# Reversible-Cell Ripple Adder

This block adds two 4-bit operands and a carry-in using a chain of identical four-line reversible cells, one cell per bit position. Each cell maps its four input lines onto four output lines one-to-one, so no information is lost inside a cell. The carry travels from bit 0 to the top bit, and two unused outputs per cell leave the block as a spare (garbage) vector. Across the whole block, thirteen input bits map to thirteen output bits.

A per-bit control vector selects the job of each cell. With a control bit at 0, the cell is a full adder. With a control bit at 1, the same cell computes a full-subtractor difference and borrow, so the bit passes a borrow to the next position instead of a carry. The block has no clock and no state. It is placed where a datapath needs an adder whose inputs can be recovered from its outputs.

Top module: `revcell_adder`

## Requirements
- R1: Each cell maps its 16 input patterns (mode, link, xa, yb) onto 16 distinct output patterns (thru, side, link_o, bit_o).
- R2: With mode = 0, a cell gives link_o = carry and bit_o = sum of link + xa + yb. It also gives thru = link and side = xa.
- R3: With mode = 1, a cell gives bit_o = low bit of (link − xa − yb) and link_o = 1 exactly when link < xa + yb. It also gives thru = link and side = NOT yb.
- R4: Bit i drives opnd_x[i] into xa, opnd_y[i] into yb, ctl_k[i] into mode, and the incoming carry into link. Bit 0 takes carry_in as its incoming carry, and bit i+1 takes link_o of bit i. The spare outputs are spare_o[2i] = thru and spare_o[2i+1] = side of bit i.
- R5: With ctl_k = 0, {carry_out, sum_o} equals opnd_x + opnd_y + carry_in for all 512 operand and carry combinations.
- R6: With ctl_k all ones, every bit follows the borrow recurrence of R3. bit 0 starts from carry_in, and carry_out is the link_o of the top bit.
- R7: With mixed ctl_k values, each bit position follows R2 or R3 according to its own control bit, whatever the other bits select.
- R8: The whole block is bijective. The 8192 input words {ctl_k, opnd_x, opnd_y, carry_in} give 8192 distinct output words {carry_out, sum_o, spare_o}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x | input | 4 | First operand |
| opnd_y | input | 4 | Second operand |
| ctl_k | input | 4 | Per-bit mode control: 0 adds, 1 subtracts |
| carry_in | input | 1 | Carry (or borrow) into bit 0 |
| sum_o | output | 4 | Sum or difference bits |
| carry_out | output | 1 | Carry (or borrow) out of the top bit |
| spare_o | output | 8 | Unused cell outputs, two per bit |

## Verification
The block has no stored state, so a wrong internal value shows at the ports in the same cycle as the input that causes it. A cell function that is wrong in one term reaches sum_o directly. It reaches the higher sum bits and carry_out through the ripple, and only for input patterns that make that term matter. This is why the bench drives every one of the 8192 input words. A cell that loses reversibility shows up as two input words with the same output word, even when the sum itself stays correct. A mis-wired spare bit shows up in spare_o and in nothing else.

// File: rtl/revadd_pkg.sv
package revadd_pkg;

    // Cell input lines: mode selects add/subtract, link is the chained carry.
    typedef struct packed {
        logic mode;
        logic link;
        logic xa;
        logic yb;
    } cell_in_t;

    // Cell output lines: thru and side are spare, link_o chains, bit_o is the result bit.
    typedef struct packed {
        logic thru;
        logic side;
        logic link_o;
        logic bit_o;
    } cell_out_t;

    function automatic cell_out_t cell_fwd(input cell_in_t i);
        cell_out_t o;
        o.thru   = i.link;
        o.side   = (~i.mode & i.xa) | (i.mode & ~i.yb);
        o.link_o = ((i.mode ^ i.link) & (i.xa ^ i.yb)) ^ (i.xa & i.yb);
        o.bit_o  = i.link ^ i.xa ^ i.yb;
        return o;
    endfunction

    // Inverse mapping: recovers the input lines from the output lines.
    function automatic cell_in_t cell_inv(input cell_out_t o);
        cell_in_t i;
        i.link = o.thru;
        if (o.bit_o ^ o.thru) begin
            i.mode = o.link_o ^ o.thru;
            i.xa   = o.side;
            i.yb   = ~o.side;
        end else begin
            i.xa   = o.link_o;
            i.yb   = o.link_o;
            i.mode = o.side ^ o.link_o;
        end
        return i;
    endfunction

endpackage

// File: rtl/revadd_cell.sv
module revadd_cell
    import revadd_pkg::*;
(
    input  cell_in_t  cell_i,
    output cell_out_t cell_o
);

    always_comb begin
        cell_o = cell_fwd(cell_i);
    end

    always_comb begin
        logic [1:0] tot;
        logic [1:0] dif;
        tot = {1'b0, cell_i.link} + {1'b0, cell_i.xa} + {1'b0, cell_i.yb};
        dif = {1'b0, cell_i.link} - {1'b0, cell_i.xa} - {1'b0, cell_i.yb};
        assert_cell_bijective_R1: assert (cell_inv(cell_o) == cell_i)
            else $error("R1: cell output does not invert back to its input");
        if (!cell_i.mode) begin
            assert_cell_add_R2: assert ({cell_o.link_o, cell_o.bit_o} == tot)
                else $error("R2: cell add result wrong");
        end else begin
            assert_cell_sub_R3: assert (cell_o.bit_o == dif[0] &&
                                        cell_o.link_o == ({1'b0, cell_i.link} <
                                        ({1'b0, cell_i.xa} + {1'b0, cell_i.yb})))
                else $error("R3: cell subtract result wrong");
        end
    end

endmodule

// File: rtl/revadd_stage.sv
module revadd_stage
    import revadd_pkg::*;
(
    input  logic       mode_i,
    input  logic       x_i,
    input  logic       y_i,
    input  logic       link_i,
    output logic       bit_o,
    output logic       link_o,
    output logic [1:0] spare_o
);

    cell_in_t  lines_in;
    cell_out_t lines_out;

    always_comb begin
        lines_in.mode = mode_i;
        lines_in.link = link_i;
        lines_in.xa   = x_i;
        lines_in.yb   = y_i;
    end

    revadd_cell u_cell (
        .cell_i (lines_in),
        .cell_o (lines_out)
    );

    assign bit_o      = lines_out.bit_o;
    assign link_o     = lines_out.link_o;
    assign spare_o[0] = lines_out.thru;
    assign spare_o[1] = lines_out.side;

    always_comb begin
        assert_spare_map_R4: assert (spare_o[0] == link_i &&
                                     spare_o[1] == (mode_i ? ~y_i : x_i))
            else $error("R4: spare bits of stage mis-mapped");
    end

endmodule

// File: rtl/revcell_adder.sv
module revcell_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]   opnd_x,
    input  logic [WIDTH-1:0]   opnd_y,
    input  logic [WIDTH-1:0]   ctl_k,
    input  logic               carry_in,
    output logic [WIDTH-1:0]   sum_o,
    output logic               carry_out,
    output logic [2*WIDTH-1:0] spare_o
);

    localparam int CHAIN = WIDTH + 1;

    logic [CHAIN-1:0] chain;

    assign chain[0]  = carry_in;
    assign carry_out = chain[CHAIN-1];

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        revadd_stage u_stage (
            .mode_i  (ctl_k[g]),
            .x_i     (opnd_x[g]),
            .y_i     (opnd_y[g]),
            .link_i  (chain[g]),
            .bit_o   (sum_o[g]),
            .link_o  (chain[g+1]),
            .spare_o (spare_o[2*g +: 2])
        );
    end

endmodule

// File: tb/revcell_adder_bench.sv
`timescale 1ns/1ps
module revcell_adder_bench;
    import revadd_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [3:0] x, y, k;
    logic       ci;
    logic [3:0] sum;
    logic       co;
    logic [7:0] spare;

    cell_in_t  c_in;
    cell_out_t c_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    revcell_adder u_revcell_adder (
        .opnd_x    (x),
        .opnd_y    (y),
        .ctl_k     (k),
        .carry_in  (ci),
        .sum_o     (sum),
        .carry_out (co),
        .spare_o   (spare)
    );

    revadd_cell u_cell (
        .cell_i (c_in),
        .cell_o (c_out)
    );

    typedef struct packed {
        logic [3:0] k;
        logic [3:0] x;
        logic [3:0] y;
        logic       ci;
        logic       co;
        logic [3:0] s;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{k:4'h0, x:4'h3, y:4'h5, ci:1'b0, co:1'b0, s:4'h8},
        '{k:4'h0, x:4'hF, y:4'h1, ci:1'b0, co:1'b1, s:4'h0},
        '{k:4'h0, x:4'hF, y:4'hF, ci:1'b1, co:1'b1, s:4'hF},
        '{k:4'h0, x:4'h0, y:4'h0, ci:1'b1, co:1'b0, s:4'h1},
        '{k:4'h0, x:4'hA, y:4'h5, ci:1'b0, co:1'b0, s:4'hF},
        '{k:4'hF, x:4'h0, y:4'h0, ci:1'b0, co:1'b0, s:4'h0},
        '{k:4'hF, x:4'h1, y:4'h0, ci:1'b0, co:1'b0, s:4'h3},
        '{k:4'hF, x:4'h0, y:4'h0, ci:1'b1, co:1'b0, s:4'h1},
        '{k:4'hF, x:4'hF, y:4'hF, ci:1'b0, co:1'b1, s:4'hE}
    };

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h (k=%h x=%h y=%h ci=%b)",
                     req, act, exp, k, x, y, ci);
        end
    endtask

    // Reference from the requirements: per-bit add (R2) or borrow (R3) with the R4 wiring.
    function automatic logic [12:0] model(input logic [3:0] mk, input logic [3:0] mx,
                                          input logic [3:0] my, input logic mc);
        logic       b;
        logic [3:0] s;
        logic [7:0] g;
        b = mc;
        for (int i = 0; i < 4; i++) begin
            g[2*i] = b;
            s[i]   = b ^ mx[i] ^ my[i];
            if (mk[i]) begin
                g[2*i+1] = ~my[i];
                b = ({1'b0, b} < ({1'b0, mx[i]} + {1'b0, my[i]}));
            end else begin
                g[2*i+1] = mx[i];
                b = (({1'b0, b} + {1'b0, mx[i]} + {1'b0, my[i]}) >= 2'd2);
            end
        end
        return {b, s, g};
    endfunction

    task automatic drive(input logic [3:0] vk, input logic [3:0] vx,
                         input logic [3:0] vy, input logic vc);
        @(posedge clk);
        k = vk; x = vx; y = vy; ci = vc;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20.0 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    bit seen [8192];

    initial begin
        k = '0; x = '0; y = '0; ci = 1'b0;
        c_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5: all-zero inputs give all-zero outputs
        check("R5 reset", {co, sum, spare}, 13'd0);
        rst = 1'b0;

        // Table of hand-worked vectors (R5 add, R6 borrow chain)
        foreach (VECS[i]) begin
            drive(VECS[i].k, VECS[i].x, VECS[i].y, VECS[i].ci);
            check(VECS[i].k == 4'h0 ? "R5 table" : "R6 table",
                  {8'd0, co, sum}, {8'd0, VECS[i].co, VECS[i].s});
        end

        // Exhaustive: R4 wiring, R5 add, R6 subtract, R7 mixed; R8 distinctness
        for (int w = 0; w < 8192; w++) begin
            logic [12:0] word;
            logic [12:0] inw;
            inw = 13'(w);
            drive(inw[12:9], inw[8:5], inw[4:1], inw[0]);
            word = {co, sum, spare};
            if (k == 4'h0)      check("R5/R4", word, model(k, x, y, ci));
            else if (k == 4'hF) check("R6/R4", word, model(k, x, y, ci));
            else                check("R7/R4", word, model(k, x, y, ci));
            if (k == 4'h0) check("R5 arith", {8'd0, co, sum}, {8'd0, 5'(x) + 5'(y) + 5'(ci)});
            if (seen[word]) begin
                n_checks++;
                n_errors++;
                $display("FAIL R8: actual=repeat of %h expected=unique", word);
            end
            seen[word] = 1'b1;
        end
        begin
            int uniq;
            uniq = 0;
            for (int w = 0; w < 8192; w++) if (seen[w]) uniq++;
            check("R8 count", 13'(uniq % 8192), 13'(8192 % 8192));
            check("R8 full", {12'd0, uniq == 8192}, 13'd1);
        end

        // Single cell: R1 bijection, R2 add mode, R3 subtract mode
        begin
            bit cseen [16];
            int cuniq;
            cuniq = 0;
            for (int p = 0; p < 16; p++) begin
                logic [1:0] dif;
                @(posedge clk);
                c_in = cell_in_t'(4'(p));
                @(negedge clk);
                if (!cseen[c_out]) cuniq++;
                cseen[c_out] = 1'b1;
                if (!c_in.mode) begin
                    check("R2", {9'd0, c_out},
                          {9'd0, c_in.link, c_in.xa,
                           2'({1'b0, c_in.link} + {1'b0, c_in.xa} + {1'b0, c_in.yb})});
                end else begin
                    dif = {1'b0, c_in.link} - {1'b0, c_in.xa} - {1'b0, c_in.yb};
                    check("R3", {9'd0, c_out},
                          {9'd0, c_in.link, ~c_in.yb,
                           ({1'b0, c_in.link} < ({1'b0, c_in.xa} + {1'b0, c_in.yb})), dif[0]});
                end
            end
            check("R1", 13'(cuniq), 13'd16);
        end

        finish_run();
    end

endmodule